// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the command front end of a serially attached memory device, responsible for the write-enable latch. Every operation that can change the memory must pass this latch. The block oversamples the serial clock, the active-low chip select and the serial data input on its own system clock. Opcodes arrive most significant bit first. The block sets or clears the latch only when chip select is released on a whole-byte boundary. If the release comes early or mid-byte, the command is dropped without any indication.

The latch drives a write-permit output for the program and erase engines and a plain status output. The engines pulse `modDone` when they accept a modifying command, and that pulse clears the latch. A status-read opcode returns a one-byte status word on the serial output. The latch sits in bit 1 of that byte, and every other bit is zero. A separate output-enable pin controls the serial output driver. For every other transaction the driver stays high-impedance.

Top module: `welc_top`

## Requirements
- R1: After reset, `welStatus`, `writePermit` and `spiSoOe` are all 0.
- R2: Opcode 0x06, shifted most significant bit first on rising SCK edges while chip select is low, sets the latch to 1 when chip select is released after exactly 8 bits.
- R3: Opcode 0x04, under the same framing, clears the latch to 0 when chip select is released after exactly 8 bits.
- R4: The latch does not change when the eighth bit arrives. It changes only after chip select is released.
- R5: If chip select is released before 8 bits have been received, the latch keeps its value.
- R6: If chip select is released after 8 or more bits at a count that is not a multiple of 8, the latch keeps its value.
- R7: Whole bytes shifted in after the opcode are ignored. A 0x06 or 0x04 transaction of 16, 24 or more bits (any multiple of 8) acts like one of exactly 8 bits.
- R8: A one-cycle pulse on `modDone` clears the latch.
- R9: `writePermit` and `welStatus` always equal the latch.
- R10: `spiSoOe` is 0 whenever chip select is high, and 0 throughout any transaction whose opcode is not 0x05.
- R11: Opcode 0x05 enables the serial output after the falling SCK edge that follows the eighth bit. The block then shifts out, on falling edges and most significant bit first, the byte whose bit 1 is the latch and whose other bits are 0. The byte repeats for each further byte.
- R12: Opcodes other than 0x06 and 0x04 leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | Serial clock from the host |
| spiCsN | input | 1 | Active-low chip select |
| spiSi | input | 1 | Serial data in, most significant bit first |
| modDone | input | 1 | One-cycle pulse: a gated modifying command was accepted |
| spiSo | output | 1 | Serial data out (status byte) |
| spiSoOe | output | 1 | Output enable for the serial data out driver |
| writePermit | output | 1 | Permission for program and erase logic |
| welStatus | output | 1 | Latch value as a status bit |

## Verification
On every cycle, the assertions check three things. The latch moves only on a chip-select release or a `modDone` pulse. An early or mid-byte release leaves it unchanged, and a `modDone` pulse always clears it. Chip select high keeps the bit counter clear and the output driver off, and the driver turns on only for the status opcode. Some behaviour only the bench's transactions can show. Those are the values the latch takes for each opcode and bit length. So are the serial bit order of the returned status byte and the fact that trailing whole bytes are ignored.

// File: rtl/welc_pkg.sv
package welc_pkg;
  localparam logic [7:0] OP_SET  = 8'h06;
  localparam logic [7:0] OP_CLR  = 8'h04;
  localparam logic [7:0] OP_STAT = 8'h05;

  typedef struct packed {
    logic loadStatus;
    logic shiftOut;
  } dpStrobe_t;
endpackage

// File: rtl/welc_datapath.sv
module welc_datapath
  import welc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              siIn,
  input  dpStrobe_t         ctl,
  input  logic [BYTE_W-1:0] statusByte,
  output logic              sckFall,
  output logic              csRise,
  output logic              csHigh,
  output logic [CNT_W-1:0]  bitCount,
  output logic [BYTE_W-1:0] opcode,
  output logic              opValid,
  output logic              soData,
  output logic              soOe
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [SYNC_LEN:0]   sckPipe;
  logic [SYNC_LEN:0]   csPipe;
  logic [SYNC_LEN-1:0] siPipe;
  logic                sckRise;
  logic                siBit;
  logic [BYTE_W-1:0]   shiftReg;
  logic [BYTE_W-1:0]   nextShift;
  logic [BYTE_W-1:0]   outReg;

  // input synchronizers with one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[SYNC_LEN-1:0], sckIn};
      csPipe  <= {csPipe[SYNC_LEN-1:0], csNIn};
      siPipe  <= {siPipe[SYNC_LEN-2:0], siIn};
    end
  end

  assign sckRise = sckPipe[SYNC_LEN-1] & ~sckPipe[SYNC_LEN];
  assign sckFall = ~sckPipe[SYNC_LEN-1] & sckPipe[SYNC_LEN];
  assign csHigh  = csPipe[SYNC_LEN-1];
  assign csRise  = csPipe[SYNC_LEN-1] & ~csPipe[SYNC_LEN];
  assign siBit   = siPipe[SYNC_LEN-1];

  assign nextShift = {shiftReg[BYTE_W-2:0], siBit};

  // receive path: counter, shifter, opcode capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      opValid  <= 1'b0;
    end else if (csHigh) begin
      bitCount <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      opValid  <= 1'b0;
    end else if (sckRise) begin
      shiftReg <= nextShift;
      bitCount <= bitCount + CNT_W'(1);
      if (!opValid && bitCount[IDX_W-1:0] == IDX_W'(BYTE_W - 1)) begin
        opcode  <= nextShift;
        opValid <= 1'b1;
      end
    end
  end

  // transmit path: status byte shifter and driver enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      soOe   <= 1'b0;
    end else if (csHigh) begin
      outReg <= '0;
      soOe   <= 1'b0;
    end else if (ctl.loadStatus) begin
      outReg <= statusByte;
      soOe   <= 1'b1;
    end else if (ctl.shiftOut) begin
      outReg <= {outReg[BYTE_W-2:0], 1'b0};
    end
  end

  assign soData = outReg[BYTE_W-1];

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (!soOe && bitCount == '0 && !opValid));

  // R2
  opcode_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opValid) |-> $past(sckRise));
endmodule

// File: rtl/welc_control.sv
module welc_control
  import welc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WEL_POS = 1,
  localparam int IDX_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckFall,
  input  logic              csRise,
  input  logic              csHigh,
  input  logic [IDX_W-1:0]  bitLow,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              opValid,
  input  logic              soOe,
  input  logic              modDone,
  output dpStrobe_t         ctl,
  output logic              wel,
  output logic [BYTE_W-1:0] statusByte
);
  logic byteEdge;
  logic commitOk;
  logic welNext;

  assign byteEdge = (bitLow == '0);
  assign commitOk = csRise & opValid & byteEdge;

  always_comb begin
    welNext = wel;
    if (modDone) begin
      welNext = 1'b0;
    end else if (commitOk) begin
      if (opcode == BYTE_W'(OP_SET))      welNext = 1'b1;
      else if (opcode == BYTE_W'(OP_CLR)) welNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wel <= 1'b0;
    else       wel <= welNext;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[WEL_POS] = wel;
  end

  always_comb begin
    ctl.loadStatus = sckFall & ~csHigh & opValid & byteEdge &
                     (opcode == BYTE_W'(OP_STAT));
    ctl.shiftOut   = sckFall & ~csHigh & soOe & ~ctl.loadStatus;
  end

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csRise && !modDone) |=> $stable(wel));

  // R5 R6
  abort_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && !(opValid && byteEdge) && !modDone) |=> $stable(wel));

  // R8
  mod_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modDone |=> !wel);

  // R11
  oe_stat_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> (opValid && opcode == BYTE_W'(OP_STAT)));
endmodule

// File: rtl/welc_top.sv
module welc_top
  import welc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSck,
  input  logic spiCsN,
  input  logic spiSi,
  input  logic modDone,
  output logic spiSo,
  output logic spiSoOe,
  output logic writePermit,
  output logic welStatus
);
  localparam int IDX_W = $clog2(BYTE_W);

  dpStrobe_t         ctl;
  logic              sckFall;
  logic              csRise;
  logic              csHigh;
  logic [CNT_W-1:0]  bitCount;
  logic [BYTE_W-1:0] opcode;
  logic              opValid;
  logic              soOe;
  logic              soData;
  logic              wel;
  logic [BYTE_W-1:0] statusByte;

  welc_datapath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SYNC_LEN(SYNC_LEN)) uDp (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiSi),
    .ctl(ctl), .statusByte(statusByte), .sckFall(sckFall), .csRise(csRise),
    .csHigh(csHigh), .bitCount(bitCount), .opcode(opcode), .opValid(opValid),
    .soData(soData), .soOe(soOe)
  );

  welc_control #(.BYTE_W(BYTE_W)) uCtl (
    .clk(clk), .rstN(rstN), .sckFall(sckFall), .csRise(csRise),
    .csHigh(csHigh), .bitLow(bitCount[IDX_W-1:0]), .opcode(opcode),
    .opValid(opValid), .soOe(soOe), .modDone(modDone), .ctl(ctl),
    .wel(wel), .statusByte(statusByte)
  );

  assign spiSo       = soData;
  assign spiSoOe     = soOe;
  assign writePermit = wel;
  assign welStatus   = wel;
endmodule

// File: tb/tb_welc_top.sv
module tb_welc_top;
  localparam int PERIOD = 10;
  localparam int HP     = 6;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, si = 1'b0, modDone = 1'b0;
  logic so, soOe, permit, welS;
  int   total = 0, bad = 0;
  bit   expWel = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  welc_top dut (
    .clk(clk), .rstN(rstN), .spiSck(sck), .spiCsN(csN), .spiSi(si),
    .modDone(modDone), .spiSo(so), .spiSoOe(soOe),
    .writePermit(permit), .welStatus(welS)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit modelWel(input logic [7:0] op, input int n, input bit cur);
    if (n < 8 || (n % 8) != 0) return cur;
    if (op == 8'h06) return 1'b1;
    if (op == 8'h04) return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] modelStatus(input bit w);
    return {6'b0, w, 1'b0};
  endfunction

  // one transaction of n bits, opcode first, then filler data
  task automatic xfer(input string req, input logic [7:0] op, input int n);
    logic [63:0] bits;
    logic [7:0]  rd;
    bit          anyOe;
    bit          nextWel;
    bits  = {op, $urandom(), 24'($urandom())};
    rd    = '0;
    anyOe = 1'b0;
    @(negedge clk);
    csN = 1'b0;
    waitClk(HP);
    for (int i = 0; i < n; i++) begin
      si = bits[63-i];
      waitClk(HP);
      if (soOe) anyOe = 1'b1;
      if (i >= 8 && i < 16) rd = {rd[6:0], so};
      sck = 1'b1;
      waitClk(HP);
      sck = 1'b0;
    end
    waitClk(HP);
    if (soOe) anyOe = 1'b1;
    // R4: nothing committed before release
    check("R4", "latch before release", welS, expWel);
    check("R10/R11", "output enable during frame", anyOe,
          (op == 8'h05 && n >= 8));
    if (op == 8'h05 && n >= 16)
      check("R11", "status byte", rd, modelStatus(expWel));
    csN = 1'b1;
    waitClk(10);
    nextWel = modelWel(op, n, expWel);
    expWel  = nextWel;
    check(req, "latch after release", welS, expWel);
    check("R9", "permit mirrors latch", permit, welS);
    check("R10", "driver off with cs high", soOe, 1'b0);
  endtask

  task automatic pulseMod();
    @(negedge clk);
    modDone = 1'b1;
    @(negedge clk);
    modDone = 1'b0;
    waitClk(2);
    expWel = 1'b0;
    check("R8", "cleared by modDone", welS, 1'b0);
    check("R9", "permit after modDone", permit, 1'b0);
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    waitClk(4);
    check("R1", "latch at reset", welS, 1'b0);
    check("R1", "permit at reset", permit, 1'b0);
    check("R1", "oe at reset", soOe, 1'b0);
    rstN = 1'b1;
    waitClk(4);
    check("R1", "latch after reset", welS, 1'b0);

    xfer("R2", 8'h06, 8);
    check("R2", "set latch", welS, 1'b1);
    xfer("R3", 8'h04, 8);
    check("R3", "clear latch", welS, 1'b0);
    xfer("R5", 8'h06, 5);
    check("R5", "early release keeps 0", welS, 1'b0);
    xfer("R6", 8'h06, 12);
    check("R6", "mid-byte release keeps 0", welS, 1'b0);
    xfer("R7", 8'h06, 16);
    check("R7", "trailing byte ignored", welS, 1'b1);
    xfer("R5", 8'h04, 3);
    check("R5", "early release keeps 1", welS, 1'b1);
    xfer("R6", 8'h04, 15);
    check("R6", "mid-byte release keeps 1", welS, 1'b1);
    xfer("R12", 8'h9f, 8);
    check("R12", "other opcode", welS, 1'b1);
    xfer("R11", 8'h05, 24);
    check("R11", "status read keeps latch", welS, 1'b1);
    xfer("R7", 8'h04, 24);
    check("R7", "three-byte clear", welS, 1'b0);
    xfer("R11", 8'h05, 16);
    xfer("R2", 8'h06, 8);
    pulseMod();

    for (int t = 0; t < 70; t++) begin
      logic [7:0] op;
      int         n;
      case ($urandom_range(0, 4))
        0, 1: op = 8'h06;
        2:    op = 8'h04;
        3:    op = 8'h05;
        default: op = 8'($urandom());
      endcase
      n = int'($urandom_range(1, 40));
      if ($urandom_range(0, 2) == 0) n = 8 * int'($urandom_range(1, 5));
      xfer("R12", op, n);
      if ($urandom_range(0, 7) == 0) pulseMod();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule